// File: doc/BRIEF.md
# Flash Page Programming Controller

This block sits between an 8-bit CPU bus and an on-chip flash array. Software first sets a latch-enable bit in a control register. CPU data writes in the lower 32 KB window then land in a 128-byte column latch and do not reach data memory. A two-write key sequence in the upper nibble of the control register then starts programming of one page. The written latch bytes are copied into one of three target spaces: the main user space, a 128-byte extra row, or a single security byte.

The same two space-select bits steer code-fetch reads. A code read can return the user space, the extra row or the security byte, and unmapped addresses read as erased (FFh). A busy flag stays high for a fixed number of cycles while a page is programmed. The array is a behavioural model with `NUM_PAGES` pages, and the page number is taken modulo that count. Flash cell timing and erase are not modelled. The array starts erased at reset.

Top module: `flash_page_ctl`

## Requirements
- R1: After reset the control readback `ctl_rdata` is 00h (latch disabled, space 00, not busy), the latch holds no valid bytes, and every code read returns FFh.
- R2: With latch enable (control bit 0) set and `daddr[15]`=0, a data write is captured into the latch and raises neither `int_we` nor `ext_we`, whatever `ext_sel` is.
- R3: A data write that is not captured (latch disabled, or `daddr[15]`=1) raises `int_we` when `ext_sel`=0 and `ext_we` when `ext_sel`=1, in the same cycle.
- R4: Address bits 6:0 pick the latch byte and bits 14:7 pick the page to program, taken modulo `NUM_PAGES`. The page used is the one from the most recent captured write.
- R5: Control bits 2:1 select the space. 00 is user space (code address 0000h-7FFFh, aliased modulo the array size), 01 is the extra row (FF80h-FFFFh), 10 is the security byte (0000h only), and 11 is reserved. Every other code address reads FFh.
- R6: Programming starts when a control write carrying key 5h in bits 7:4 is followed, on the very next control write, by key Ah. Bits 3:0 of those writes play no part in the key match; they set the configuration. The space used is the one given in the second write.
- R7: A control write whose key is not the expected next value returns the sequence to idle, and nothing is launched.
- R8: The busy flag (control bit 3) is high for exactly `PROG_CYCLES` cycles after the launching write and then clears.
- R9: On completion, only the latch bytes written since the last completion are stored into the target page. All valid flags are then cleared, so a second launch with no new writes leaves the array unchanged.
- R10: A launch whose space field is 11 is rejected. Busy stays low and the latch contents stay valid.
- R11: While busy, key writes are ignored by the sequence. Data writes in the latch window with latch enabled are dropped: they are not captured and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dwr_en | input | 1 | CPU data write strobe |
| daddr | input | 16 | CPU data write address |
| dwdata | input | 8 | CPU data write byte |
| ext_sel | input | 1 | Route uncaptured data writes to external memory |
| int_we | output | 1 | Write strobe to internal data memory |
| ext_we | output | 1 | Write strobe to external data memory |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control readback: {0000, busy, space[1:0], latch enable} |
| code_addr | input | 16 | Code fetch address |
| code_rdata | output | 8 | Code fetch data from the selected space |

## Verification
Two functions can fall in the same cycle. One is a running programming operation. The other is new traffic that would feed it: a key write that could re-arm the sequence, or a latch write that could change the bytes being committed. The bench provokes both by issuing a 5h key write and a latch-window data write while busy is high. It then sends a lone Ah key after busy falls and checks that busy does not rise. A full relaunch follows, and a sweep of the whole user space checks that the dropped byte never reached the array.

// File: rtl/flash_pkg.sv
// Shared definitions for the flash page programming controller.
// Assumes an 8-bit control register whose bit positions are given here.
package flash_pkg;
    typedef enum logic [1:0] {
        SP_USER = 2'b00,
        SP_XROW = 2'b01,
        SP_SECB = 2'b10,
        SP_RSVD = 2'b11
    } space_e;

    localparam int          PAGE_BYTES = 128;
    localparam int          OFS_W      = 7;
    localparam int          CTL_LAT    = 0;
    localparam int          CTL_BUSY   = 3;
    localparam logic [3:0]  KEY_FIRST  = 4'h5;
    localparam logic [3:0]  KEY_SECOND = 4'hA;
endpackage

// File: rtl/flash_ctl_reg.sv
// Control register, launch-key sequencer and busy timer.
// Assumes PROG_CYCLES >= 1. Key writes are ignored while busy; the space
// used for a launch is taken from the second key write itself.
module flash_ctl_reg
    import flash_pkg::*;
#(
    parameter int PROG_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic       lat_en,
    output space_e     rd_mode,
    output logic       busy,
    output logic       commit,
    output space_e     prog_mode
);
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    typedef enum logic {KS_IDLE, KS_ARMED} kstate_e;

    kstate_e           ks;
    logic [CNT_W-1:0]  cnt;
    logic [3:0]        key_in;
    space_e            wr_mode;
    logic              key_ok;
    logic              launch;

    assign key_in  = ctl_wdata[7:4];
    assign wr_mode = space_e'(ctl_wdata[2:1]);
    assign key_ok  = ctl_wr && !busy;
    assign launch  = key_ok && (ks == KS_ARMED) && (key_in == KEY_SECOND)
                     && (wr_mode != SP_RSVD);
    assign commit  = busy && (cnt == '0);

    // Configuration bits: latch enable and space select follow every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_en  <= 1'b0;
            rd_mode <= SP_USER;
        end else if (ctl_wr) begin
            lat_en  <= ctl_wdata[CTL_LAT];
            rd_mode <= wr_mode;
        end
    end

    // Key sequencer: 5h arms, the next write must be Ah, anything else idles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks <= KS_IDLE;
        end else if (key_ok) begin
            if (ks == KS_IDLE && key_in == KEY_FIRST)
                ks <= KS_ARMED;
            else
                ks <= KS_IDLE;
        end
    end

    // Busy timer: holds busy for PROG_CYCLES cycles and latches the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            prog_mode <= SP_USER;
        end else if (launch) begin
            busy      <= 1'b1;
            cnt       <= CNT_W'(PROG_CYCLES - 1);
            prog_mode <= wr_mode;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/flash_col_latch.sv
// 128-byte column latch with per-byte valid flags and the target page.
// Assumes wr and clr never coincide (the top blocks writes while busy).
module flash_col_latch
    import flash_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [OFS_W-1:0]            ofs,
    input  logic [7:0]                  page_in,
    input  logic [7:0]                  wdata,
    input  logic                        clr,
    output logic [PAGE_BYTES-1:0][7:0]  data,
    output logic [PAGE_BYTES-1:0]       valid,
    output logic [7:0]                  page
);
    // Valid flags and page number: set by captures, wiped on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            page  <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr) begin
            valid[ofs] <= 1'b1;
            page       <= page_in;
        end
    end

    // Byte storage: one register per column, written by address offset.
    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data[g] <= 8'h00;
                else if (wr && ofs == OFS_W'(g))
                    data[g] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/flash_array_model.sv
// Behavioural flash array: user pages, one extra row and a security byte.
// Assumes NUM_PAGES is a power of two from 2 to 256; starts erased (FFh).
// Programming overwrites only the bytes flagged valid in the latch.
module flash_array_model
    import flash_pkg::*;
#(
    parameter int NUM_PAGES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  space_e                      prog_mode,
    input  logic [7:0]                  prog_page,
    input  logic [PAGE_BYTES-1:0][7:0]  lat_data,
    input  logic [PAGE_BYTES-1:0]       lat_valid,
    input  space_e                      rd_mode,
    input  logic [15:0]                 code_addr,
    output logic [7:0]                  code_rdata
);
    localparam int PG_W       = $clog2(NUM_PAGES);
    localparam int USER_BYTES = NUM_PAGES * PAGE_BYTES;
    localparam int UA_W       = PG_W + OFS_W;

    logic [7:0]      user_mem [USER_BYTES];
    logic [7:0]      xrow_mem [PAGE_BYTES];
    logic [7:0]      sec_byte;
    logic [PG_W-1:0] pg;
    logic [UA_W-1:0] uidx;

    assign pg   = PG_W'({1'b0, prog_page} % 9'(NUM_PAGES));
    assign uidx = UA_W'({1'b0, code_addr[14:0]} % 16'(USER_BYTES));

    // User space: erase at reset, then program valid bytes of one page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < USER_BYTES; i++) user_mem[i] <= 8'hFF;
        end else if (commit && prog_mode == SP_USER) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (lat_valid[i]) user_mem[{pg, OFS_W'(i)}] <= lat_data[i];
        end
    end

    // Extra row and security byte: same commit rule, own target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) xrow_mem[i] <= 8'hFF;
            sec_byte <= 8'hFF;
        end else if (commit && prog_mode == SP_XROW) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (lat_valid[i]) xrow_mem[i] <= lat_data[i];
        end else if (commit && prog_mode == SP_SECB && lat_valid[0]) begin
            sec_byte <= lat_data[0];
        end
    end

    // Code-read steering: mapped address of the selected space, else FFh.
    always_comb begin
        code_rdata = 8'hFF;
        unique case (rd_mode)
            SP_USER: if (!code_addr[15])      code_rdata = user_mem[uidx];
            SP_XROW: if (&code_addr[15:7])    code_rdata = xrow_mem[code_addr[6:0]];
            SP_SECB: if (code_addr == 16'h0)  code_rdata = sec_byte;
            default: code_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/flash_page_ctl.sv
// Top: decodes CPU data writes into latch captures or memory strobes,
// and joins the control register, column latch and array model.
// Assumes single-cycle write strobes; captures are dropped while busy.
module flash_page_ctl
    import flash_pkg::*;
#(
    parameter int NUM_PAGES   = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dwr_en,
    input  logic [15:0] daddr,
    input  logic [7:0]  dwdata,
    input  logic        ext_sel,
    output logic        int_we,
    output logic        ext_we,
    input  logic        ctl_wr,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic [15:0] code_addr,
    output logic [7:0]  code_rdata
);
    logic                        lat_en;
    space_e                      rd_mode;
    logic                        busy;
    logic                        commit;
    space_e                      prog_mode;
    logic                        capture_req;
    logic                        lat_wr;
    logic                        pass;
    logic [PAGE_BYTES-1:0][7:0]  lat_data;
    logic [PAGE_BYTES-1:0]       lat_valid;
    logic [7:0]                  lat_page;

    // Write decode: latch enable overrides the external-memory select.
    always_comb begin
        capture_req = dwr_en && lat_en && !daddr[15];
        lat_wr      = capture_req && !busy;
        pass        = dwr_en && !capture_req;
        int_we      = pass && !ext_sel;
        ext_we      = pass && ext_sel;
    end

    assign ctl_rdata = {4'b0000, busy, rd_mode, lat_en};

    flash_ctl_reg #(.PROG_CYCLES(PROG_CYCLES)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .lat_en    (lat_en),
        .rd_mode   (rd_mode),
        .busy      (busy),
        .commit    (commit),
        .prog_mode (prog_mode)
    );

    flash_col_latch u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (lat_wr),
        .ofs     (daddr[6:0]),
        .page_in (daddr[14:7]),
        .wdata   (dwdata),
        .clr     (commit),
        .data    (lat_data),
        .valid   (lat_valid),
        .page    (lat_page)
    );

    flash_array_model #(.NUM_PAGES(NUM_PAGES)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .prog_mode  (prog_mode),
        .prog_page  (lat_page),
        .lat_data   (lat_data),
        .lat_valid  (lat_valid),
        .rd_mode    (rd_mode),
        .code_addr  (code_addr),
        .code_rdata (code_rdata)
    );
endmodule

// File: rtl/flash_page_ctl_chk.sv
// Port-level checker for flash_page_ctl, attached by bind below.
// Busy length is measured with a counter instead of a deep $past.
module flash_page_ctl_chk #(
    parameter int PROG_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dwr_en,
    input logic [15:0] daddr,
    input logic        ext_sel,
    input logic        int_we,
    input logic        ext_we,
    input logic        ctl_wr,
    input logic [7:0]  ctl_wdata,
    input logic [7:0]  ctl_rdata
);
    logic busy_q;
    int   bcnt;

    assign busy_q = ctl_rdata[3];

    // Counts consecutive sampled busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      bcnt <= 0;
        else if (busy_q) bcnt <= bcnt + 1;
        else             bcnt <= 0;
    end

    a_r2_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_en && ctl_rdata[0] && !daddr[15]) |-> (!int_we && !ext_we));

    a_r3_route: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_en && !ctl_rdata[0]) |-> (ext_we == ext_sel && int_we == !ext_sel));

    a_r6_key_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ($past(ctl_wr) && $past(ctl_wdata[7:4]) == 4'hA));

    a_r10_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ($past(ctl_wdata[2:1]) != 2'b11));

    a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (bcnt == PROG_CYCLES));
endmodule

bind flash_page_ctl flash_page_ctl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (.*);

// File: tb/flash_page_ctl_tb.sv
module flash_page_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 8;
    localparam int PC         = 16;
    localparam int UB         = NP * 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dwr_en = 1'b0;
    logic [15:0] daddr = '0;
    logic [7:0]  dwdata = '0;
    logic        ext_sel = 1'b0;
    logic        int_we, ext_we;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic [15:0] code_addr = '0;
    logic [7:0]  code_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mu [UB];
    logic [7:0] mx [128];
    logic [7:0] ms;
    logic [7:0] lat [128];
    bit         lv [128];
    int         lpage;
    logic       cfg_lat;
    logic [1:0] cfg_mode;

    flash_page_ctl #(.NUM_PAGES(NP), .PROG_CYCLES(PC)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        cfg_lat = v[0]; cfg_mode = v[2:1];
    endtask

    task automatic dwrite(input logic [15:0] a, input logic [7:0] d, input logic ext);
        bit cap, bsy;
        @(negedge clk);
        dwr_en = 1'b1; daddr = a; dwdata = d; ext_sel = ext;
        #1;
        cap = cfg_lat && !a[15];
        bsy = ctl_rdata[3];
        if (cap)
            chk(!int_we && !ext_we, bsy ? "R11" : "R2", "strobes on capture",
                {int_we, ext_we}, 0);
        else
            chk(int_we == !ext && ext_we == ext, "R3", "strobe routing",
                {int_we, ext_we}, {!ext, ext});
        @(negedge clk);
        dwr_en = 1'b0;
        if (cap && !bsy) begin
            lat[a[6:0]] = d; lv[a[6:0]] = 1; lpage = int'(a[14:7]);
        end
    endtask

    task automatic model_commit(input logic [1:0] m);
        for (int i = 0; i < 128; i++) begin
            if (lv[i]) begin
                if (m == 2'b00) mu[(lpage % NP) * 128 + i] = lat[i];
                if (m == 2'b01) mx[i] = lat[i];
                if (m == 2'b10 && i == 0) ms = lat[0];
            end
            lv[i] = 0;
        end
    endtask

    task automatic wait_idle(input bit measure);
        int n = 0;
        while (ctl_rdata[3] && n < 4 * PC) begin
            n++;
            @(negedge clk);
        end
        if (measure) chk(n == PC, "R8", "busy length", n, PC);
    endtask

    task automatic launch(input logic [3:0] cfg, input bit expect_go, input string req);
        ctl({4'h5, cfg});
        ctl({4'hA, cfg});
        chk(ctl_rdata[3] == expect_go, req, "busy after key pair", ctl_rdata[3], expect_go);
        if (expect_go) begin
            wait_idle(1);
            model_commit(cfg[2:1]);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
        code_addr = a;
        #1;
        chk(code_rdata === e, req, $sformatf("code read %04h", a), code_rdata, e);
    endtask

    task automatic sweep(input string req);
        @(negedge clk);
        case (cfg_mode)
            2'b00: begin
                for (int a = 0; a < UB; a++) rd(16'(a), mu[a], req);
                rd(16'h8000, 8'hFF, req);
                rd(16'hFF80, 8'hFF, req);
            end
            2'b01: begin
                for (int a = 0; a < 128; a++) rd(16'hFF80 + 16'(a), mx[a], req);
                rd(16'h0000, 8'hFF, req);
                rd(16'hFF7F, 8'hFF, req);
            end
            2'b10: begin
                rd(16'h0000, ms, req);
                rd(16'h0001, 8'hFF, req);
                rd(16'hFF80, 8'hFF, req);
            end
            default: begin
                rd(16'h0000, 8'hFF, req);
                rd(16'hFF80, 8'hFF, req);
                rd(16'h0100, 8'hFF, req);
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < UB; i++) mu[i] = 8'hFF;
        for (int i = 0; i < 128; i++) begin mx[i] = 8'hFF; lat[i] = 0; lv[i] = 0; end
        ms = 8'hFF; lpage = 0; cfg_lat = 0; cfg_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and erased array
        chk(ctl_rdata == 8'h00, "R1", "ctl readback", ctl_rdata, 0);
        sweep("R1");

        // R3: latch disabled, both routes
        dwrite(16'h0100, 8'h11, 1'b0);
        dwrite(16'h0101, 8'h22, 1'b1);

        // R2/R4: latch enabled, high address passes, page field 10 -> page 2
        ctl(8'h01);
        dwrite(16'h8005, 8'h33, 1'b0);
        for (int o = 0; o < 128; o += 2)
            dwrite(16'(10 * 128 + o), 8'(o) ^ 8'h5A, 1'(o % 4 == 0));

        // R6/R8: launch into user space, lower nibble carries config
        launch(4'h1, 1, "R6");
        sweep("R4");

        // R9: relaunch without new writes changes nothing
        launch(4'h1, 1, "R9");
        sweep("R9");

        // R5: extra row
        ctl(8'h03);
        for (int o = 0; o < 128; o += 3) dwrite(16'(o), ~8'(o), 1'b0);
        launch(4'h3, 1, "R6");
        sweep("R5");

        // R5: security byte uses offset 0 only
        ctl(8'h05);
        dwrite(16'h0000, 8'h3C, 1'b0);
        dwrite(16'h0005, 8'h77, 1'b0);
        launch(4'h5, 1, "R6");
        sweep("R5");

        // R10: reserved space rejected, latch kept for a later launch
        ctl(8'h07);
        dwrite(16'h0009, 8'h99, 1'b0);
        launch(4'h7, 0, "R10");
        repeat (3) @(negedge clk);
        chk(ctl_rdata[3] == 1'b0, "R10", "busy stays low", ctl_rdata[3], 0);
        sweep("R5");
        launch(4'h1, 1, "R10");
        sweep("R10");

        // R7: wrong middle key, and repeated first key
        ctl(8'h51); ctl(8'h31); ctl(8'hA1);
        chk(ctl_rdata[3] == 1'b0, "R7", "5-3-A no launch", ctl_rdata[3], 0);
        ctl(8'h51); ctl(8'h51); ctl(8'hA1);
        chk(ctl_rdata[3] == 1'b0, "R7", "5-5-A no launch", ctl_rdata[3], 0);

        // R11: traffic during busy
        dwrite(16'h0080 + 16'd20, 8'hEE, 1'b0);
        ctl(8'h51); ctl(8'hA1);
        chk(ctl_rdata[3] == 1'b1, "R11", "busy for overlap test", ctl_rdata[3], 1);
        dwrite(16'h0080 + 16'd21, 8'h12, 1'b0);
        ctl(8'h51);
        wait_idle(0);
        model_commit(2'b00);
        ctl(8'hA1);
        chk(ctl_rdata[3] == 1'b0, "R11", "key during busy ignored", ctl_rdata[3], 0);
        launch(4'h1, 1, "R11");
        sweep("R11");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule